// File: doc/BRIEF.md
# IOMMU Fault Recording Status Unit

This block is the fault bookkeeping end of a DMA-remapping unit. Translation faults reported by the remapping pipeline are stored in a small bank of recording slots. Each slot keeps a fault flag and a captured fault information word. The block also maintains one 32-bit status word. That word holds a live summary of pending faults, the index of the slot that held the first fault, and sticky flags for overflow and for three invalidation error conditions. Whenever hardware newly sets any of these conditions, the block can raise a one-cycle fault event toward the interrupt logic. An event control register can hold that event back.

Software reaches the block through a plain word-addressed register port: address, write data, write enable and combinational read data. It reads the status word to find out what happened. It clears recording slots and sticky flags by writing ones to them. It uses the mask bit to defer event delivery. Writes take effect at the clock edge. Reads return every field in the same cycle.

Top module: `iommu_fault_status`

## Requirements
- R1: There are NSLOT (default 8) slots. A fault presented on `fault_valid_i` goes into the lowest-numbered slot whose flag is 0, and that flag reads 1 from the following cycle. Free slots are judged on the flags before the edge. Address 2 returns the slot flags in bits [NSLOT-1:0]. Writing 1 to a bit there clears that flag.
- R2: The status word is at address 0. Its bits 31:16, bit 7 and bits 3:2 always read 0, and writes to them have no effect. Reads of unmapped addresses (3 to 7, and 8+NSLOT upward) return 0.
- R3: Status bit 1 is the pending summary. It always equals the OR of all slot flags, and writes to it are ignored.
- R4: Status bits 15:8 hold the record index. It is loaded with the number of the slot being filled whenever a fault is accepted while no flag is set, that is, when bit 1 goes from 0 to 1. Otherwise it holds its value.
- R5: Status bit 0 is the overflow flag. It is set when a fault arrives while all slots are flagged. Writing 1 to it clears it, and it resets to 0.
- R6: Status bits 6, 5 and 4 are sticky error flags. They are set by pulses on `inv_timeout_i`, `inv_cpl_err_i` and `inv_queue_err_i` respectively. Writing 1 to a bit clears it, and all three reset to 0.
- R7: When a hardware set and a write-one-to-clear hit the same bit in the same cycle, the bit ends up 1.
- R8: Address 8+n returns the fault information captured into slot n, in bits [INFO_W-1:0], with the upper bits 0.
- R9: Address 1 is event control. Bit 0 is the mask; it is read/write and resets to 1. Bit 1 is the event-pending flag; it is read-only. All other bits read 0.
- R10: An event condition occurs in any cycle where hardware sets bit 1, bit 0 or one of bits 6:4 while that bit was 0. If the mask is 0, `fault_event_o` is high for the following cycle. If the mask is 1, the event-pending flag is set instead. While the mask reads 0 and the event-pending flag is 1, the next cycle delivers one pulse and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fault_valid_i | input | 1 | Translation fault reported this cycle |
| fault_info_i | input | INFO_W | Fault information stored into the chosen slot |
| inv_timeout_i | input | 1 | Device TLB invalidation completion timeout pulse |
| inv_cpl_err_i | input | 1 | Unexpected or invalid invalidation completion pulse |
| inv_queue_err_i | input | 1 | Invalidation queue error pulse |
| reg_addr_i | input | ADDR_W | Word address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write enable |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, same cycle |
| fault_event_o | output | 1 | One-cycle fault event pulse |

## Verification
A slot flag stuck at the wrong value shows up at once in three places: the pending bit, the slot flag register, and the choice of slot for the next fault. A bench that compares every cycle therefore sees it within one access. A record index latched at the wrong moment stays wrong for as long as faults remain pending, so it is caught on the next status read. Event and mask errors appear on `fault_event_o` in the cycle after the condition, or in the second cycle after the mask is cleared. For that reason the event output is compared on every clock, while a random mix of faults, error pulses, clears and mask writes runs alongside.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int unsigned REG_W = 32;
  // status bit positions decoded by software
  localparam int unsigned ST_OVF  = 0;
  localparam int unsigned ST_PEND = 1;
  localparam int unsigned ST_ERR_LSB = 4;
  localparam int unsigned ST_IDX_LSB = 8;
  localparam int unsigned IDX_FIELD_W = 8;
  localparam int unsigned N_ERR = 3;
  // register word addresses
  localparam int unsigned A_STATUS = 0;
  localparam int unsigned A_EVCTL  = 1;
  localparam int unsigned A_SLOTS  = 2;
  localparam int unsigned A_INFO   = 8;

  typedef struct packed {
    logic timeout;
    logic cpl_err;
    logic queue_err;
  } err_vec_t;
endpackage

// File: rtl/fsu_slot_bank.sv
module fsu_slot_bank #(
  parameter int unsigned NSLOT  = 8,
  parameter int unsigned INFO_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           fault_valid_i,
  input  logic [INFO_W-1:0]              fault_info_i,
  input  logic                           clr_we_i,
  input  logic [NSLOT-1:0]               clr_bits_i,
  output logic [NSLOT-1:0]               flags_o,
  output logic [NSLOT-1:0][INFO_W-1:0]   info_o,
  output logic                           accept_o,
  output logic                           full_o,
  output logic [$clog2(NSLOT)-1:0]       alloc_idx_o
);
  localparam int unsigned IDX_W = $clog2(NSLOT);

  logic [NSLOT-1:0]             flags_q;
  logic [NSLOT-1:0][INFO_W-1:0] info_q;
  logic [IDX_W-1:0]             alloc_idx;
  logic                         found;

  // lowest free slot wins
  always_comb begin
    alloc_idx = '0;
    found     = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!flags_q[i]) begin
        alloc_idx = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

  assign accept_o    = fault_valid_i & found;
  assign full_o      = ~found;
  assign alloc_idx_o = alloc_idx;
  assign flags_o     = flags_q;
  assign info_o      = info_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit;
    assign hit = accept_o && (alloc_idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_q[g] <= 1'b0;
        info_q[g]  <= '0;
      end else begin
        if (hit) begin
          flags_q[g] <= 1'b1;
          info_q[g]  <= fault_info_i;
        end else if (clr_we_i && clr_bits_i[g]) begin
          flags_q[g] <= 1'b0;
        end
      end
    end

    a_r1_slot_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && clr_bits_i[g] && !hit) |=> !flags_q[g]);
  end

  a_r1_alloc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> flags_q[$past(alloc_idx)]);

  a_r1_full_no_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_i && full_o && !clr_we_i) |=> $stable(flags_q));
endmodule

// File: rtl/fsu_status.sv
module fsu_status
  import fsu_pkg::*;
#(
  parameter int unsigned NSLOT = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSLOT-1:0]         flags_i,
  input  logic                     accept_i,
  input  logic [$clog2(NSLOT)-1:0] alloc_idx_i,
  input  logic                     overflow_i,
  input  err_vec_t                 err_set_i,
  input  logic                     clr_we_i,
  input  logic                     clr_ovf_i,
  input  err_vec_t                 clr_err_i,
  output logic [REG_W-1:0]         status_o,
  output logic                     hw_event_o
);
  logic                   ovf_q;
  err_vec_t               err_q;
  logic [IDX_FIELD_W-1:0] idx_q;
  logic                   pending;
  logic                   rise;
  err_vec_t               err_clr;

  assign pending = |flags_i;
  assign rise    = accept_i & ~pending;
  assign err_clr = clr_we_i ? clr_err_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      err_q <= '0;
      idx_q <= '0;
    end else begin
      // set beats same-cycle clear
      ovf_q <= (ovf_q & ~(clr_we_i & clr_ovf_i)) | overflow_i;
      err_q <= (err_q & ~err_clr) | err_set_i;
      if (rise) idx_q <= IDX_FIELD_W'(alloc_idx_i);
    end
  end

  assign hw_event_o = rise | (overflow_i & ~ovf_q) | (|(err_set_i & ~err_q));

  always_comb begin
    status_o = '0;
    status_o[ST_OVF]  = ovf_q;
    status_o[ST_PEND] = pending;
    status_o[ST_ERR_LSB +: N_ERR] = err_q;
    status_o[ST_IDX_LSB +: IDX_FIELD_W] = idx_q;
  end

  a_r5_overflow_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_i |=> ovf_q);

  a_r6_queue_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q.queue_err && !err_clr.queue_err) |=> err_q.queue_err);

  a_r4_index_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending |=> $stable(idx_q));

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i.timeout && err_clr.timeout) |=> err_q.timeout);
endmodule

// File: rtl/fsu_event_ctrl.sv
module fsu_event_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic mask_o,
  output logic ip_o,
  output logic event_o
);
  logic mask_q, ip_q, event_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= 1'b1;
      ip_q    <= 1'b0;
      event_q <= 1'b0;
    end else begin
      event_q <= ~mask_q & (cond_i | ip_q);
      ip_q    <= mask_q & (ip_q | cond_i);
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign mask_o  = mask_q;
  assign ip_o    = ip_q;
  assign event_o = event_q;

  a_r10_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |=> !event_q);

  a_r10_pending_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q |=> !ip_q);

  a_r10_pending_delivered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_q && ip_q) |=> event_q);
endmodule

// File: rtl/iommu_fault_status.sv
module iommu_fault_status
  import fsu_pkg::*;
#(
  parameter int unsigned NSLOT  = 8,
  parameter int unsigned INFO_W = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_valid_i,
  input  logic [INFO_W-1:0] fault_info_i,
  input  logic              inv_timeout_i,
  input  logic              inv_cpl_err_i,
  input  logic              inv_queue_err_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_we_i,
  output logic [31:0]       reg_rdata_o,
  output logic              fault_event_o
);
  localparam int unsigned IDX_W = $clog2(NSLOT);
  localparam logic [ADDR_W-1:0] AD_STATUS = ADDR_W'(A_STATUS);
  localparam logic [ADDR_W-1:0] AD_EVCTL  = ADDR_W'(A_EVCTL);
  localparam logic [ADDR_W-1:0] AD_SLOTS  = ADDR_W'(A_SLOTS);
  localparam logic [ADDR_W-1:0] AD_INFO   = ADDR_W'(A_INFO);
  localparam logic [ADDR_W-1:0] AD_INFO_END = ADDR_W'(A_INFO + NSLOT);

  logic [NSLOT-1:0]             flags;
  logic [NSLOT-1:0][INFO_W-1:0] info;
  logic                         accept, full;
  logic [IDX_W-1:0]             alloc_idx;
  logic [REG_W-1:0]             status;
  logic                         hw_event;
  logic                         mask, ip;
  logic                         we_status, we_evctl, we_slots;
  err_vec_t                     err_set, err_clr;
  logic [ADDR_W-1:0]            info_off;
  logic                         unused_wdata;

  assign we_status = reg_we_i && (reg_addr_i == AD_STATUS);
  assign we_evctl  = reg_we_i && (reg_addr_i == AD_EVCTL);
  assign we_slots  = reg_we_i && (reg_addr_i == AD_SLOTS);

  assign err_set = '{timeout: inv_timeout_i, cpl_err: inv_cpl_err_i, queue_err: inv_queue_err_i};
  assign err_clr = reg_wdata_i[ST_ERR_LSB +: N_ERR];
  assign unused_wdata = ^reg_wdata_i;

  fsu_slot_bank #(.NSLOT(NSLOT), .INFO_W(INFO_W)) u_slots (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fault_valid_i (fault_valid_i),
    .fault_info_i  (fault_info_i),
    .clr_we_i      (we_slots),
    .clr_bits_i    (reg_wdata_i[NSLOT-1:0]),
    .flags_o       (flags),
    .info_o        (info),
    .accept_o      (accept),
    .full_o        (full),
    .alloc_idx_o   (alloc_idx)
  );

  fsu_status #(.NSLOT(NSLOT)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flags_i     (flags),
    .accept_i    (accept),
    .alloc_idx_i (alloc_idx),
    .overflow_i  (fault_valid_i & full),
    .err_set_i   (err_set),
    .clr_we_i    (we_status),
    .clr_ovf_i   (reg_wdata_i[ST_OVF]),
    .clr_err_i   (err_clr),
    .status_o    (status),
    .hw_event_o  (hw_event)
  );

  fsu_event_ctrl u_event (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_i    (hw_event),
    .mask_we_i (we_evctl),
    .mask_d_i  (reg_wdata_i[0]),
    .mask_o    (mask),
    .ip_o      (ip),
    .event_o   (fault_event_o)
  );

  assign info_off = reg_addr_i - AD_INFO;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AD_STATUS) begin
      reg_rdata_o = status;
    end else if (reg_addr_i == AD_EVCTL) begin
      reg_rdata_o[0] = mask;
      reg_rdata_o[1] = ip;
    end else if (reg_addr_i == AD_SLOTS) begin
      reg_rdata_o[NSLOT-1:0] = flags;
    end else if (reg_addr_i >= AD_INFO && reg_addr_i < AD_INFO_END) begin
      reg_rdata_o[INFO_W-1:0] = info[info_off[IDX_W-1:0]];
    end
  end

  a_r3_pending_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == AD_STATUS) |-> (reg_rdata_o[ST_PEND] == (|flags)));

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == AD_STATUS) |-> (reg_rdata_o[31:16] == '0 && !reg_rdata_o[7] && reg_rdata_o[3:2] == '0));
endmodule

// File: tb/iommu_fault_status_bench.sv
module iommu_fault_status_bench;
  localparam int NSLOT = 8;
  localparam int INFO_W = 16;
  localparam int ADDR_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              fv = 0;
  logic [INFO_W-1:0] finfo = '0;
  logic              ito = 0, ice = 0, iqe = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic              we = 0;
  logic [31:0]       rdata;
  logic              ev;

  iommu_fault_status #(.NSLOT(NSLOT), .INFO_W(INFO_W), .ADDR_W(ADDR_W)) u_iommu_fault_status (
    .clk_i(clk), .rst_ni(rst_n), .fault_valid_i(fv), .fault_info_i(finfo),
    .inv_timeout_i(ito), .inv_cpl_err_i(ice), .inv_queue_err_i(iqe),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we),
    .reg_rdata_o(rdata), .fault_event_o(ev));

  // behavioural reference state
  bit        m_flag [NSLOT];
  int        m_info [NSLOT];
  bit        m_ovf;
  bit [2:0]  m_err;  // {timeout, cpl, queue}
  int        m_idx;
  bit        m_mask, m_ip, m_ev;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NSLOT; i++) begin m_flag[i] = 0; m_info[i] = 0; end
    m_ovf = 0; m_err = 0; m_idx = 0; m_mask = 1; m_ip = 0; m_ev = 0;
  endtask

  task automatic model_step();
    int fr = -1;
    bit any = 0, acc, cond = 0;
    bit w_st, w_sl, w_ec;
    bit [2:0] eset;
    bit nf [NSLOT];
    for (int i = NSLOT - 1; i >= 0; i--) if (!m_flag[i]) fr = i;
    for (int i = 0; i < NSLOT; i++) begin any |= m_flag[i]; nf[i] = m_flag[i]; end
    acc  = fv && (fr >= 0);
    w_st = we && addr == 0;
    w_ec = we && addr == 1;
    w_sl = we && addr == 2;
    if (w_sl) for (int i = 0; i < NSLOT; i++) if (wdata[i]) nf[i] = 0;
    if (acc) begin
      nf[fr] = 1;
      m_info[fr] = int'(finfo);
      if (!any) begin m_idx = fr; cond = 1; end
    end
    for (int i = 0; i < NSLOT; i++) m_flag[i] = nf[i];
    if (fv && !acc && !m_ovf) cond = 1;
    m_ovf = (m_ovf && !(w_st && wdata[0])) || (fv && !acc);
    eset = {ito, ice, iqe};
    if ((eset & ~m_err) != 0) cond = 1;
    m_err = (m_err & ~(w_st ? wdata[6:4] : 3'b0)) | eset;
    m_ev = !m_mask && (cond || m_ip);
    m_ip = m_mask && (m_ip || cond);
    if (w_ec) m_mask = wdata[0];
  endtask

  task automatic compare();
    bit any = 0;
    logic [31:0] fl = '0;
    for (int i = 0; i < NSLOT; i++) begin any |= m_flag[i]; fl[i] = m_flag[i]; end
    chk("R10 event", {31'b0, ev}, {31'b0, m_ev});
    case (int'(addr))
      0: begin
        chk("R2 reserved", rdata & 32'hFFFF_008C, 32'h0);
        chk("R3 pending", {31'b0, rdata[1]}, {31'b0, any});
        chk("R4 index", {24'b0, rdata[15:8]}, 32'(m_idx));
        chk("R5 overflow", {31'b0, rdata[0]}, {31'b0, m_ovf});
        chk("R6 errors", {29'b0, rdata[6:4]}, {29'b0, m_err});
      end
      1: chk("R9 evctl", rdata, {30'b0, m_ip, m_mask});
      2: chk("R1 slot flags", rdata, fl);
      default: begin
        if (int'(addr) >= 8 && int'(addr) < 8 + NSLOT)
          chk("R8 slot info", rdata, 32'(m_info[int'(addr) - 8]));
        else
          chk("R2 unmapped", rdata, 32'h0);
      end
    endcase
  endtask

  task automatic cycle();
    @(negedge clk);
    if (rst_n) model_step(); else model_reset();
    compare();
    fv = 0; ito = 0; ice = 0; iqe = 0; we = 0;
  endtask

  task automatic rd(int a);
    addr = ADDR_W'(a);
    cycle();
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = ADDR_W'(a); wdata = d; we = 1;
    cycle();
  endtask

  task automatic flt(logic [INFO_W-1:0] d);
    fv = 1; finfo = d;
    cycle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    model_reset();
    // reset state: R1 R2 R9
    rd(0); rd(1); rd(2);
    rst_n = 1;
    rd(0);
    wr(1, 32'h0);                 // R9 unmask
    rd(1);
    addr = 0; flt(16'h1111);      // R1 R4 R10: first fault, event next cycle
    rd(0); rd(2); rd(8);
    for (int i = 1; i < NSLOT; i++) begin addr = 5'(8 + i); flt(16'(16'hA000 + i)); end
    addr = 0; flt(16'hDEAD);      // R5 overflow
    rd(0); rd(15);
    wr(2, 32'h0000_0008);         // R1 clear slot 3
    addr = 2; flt(16'h3333);      // refills slot 3
    rd(11); rd(2);
    wr(0, 32'hFFFF_FF8E);         // R2 R3: reserved, pending and index writes ignored
    rd(0);
    wr(0, 32'h0000_0001);         // R5 clear overflow
    rd(0);
    ito = 1; rd(0);               // R6 timeout
    ice = 1; rd(0);
    iqe = 1; rd(0);
    // R7: clear of bit 4 coincides with new queue error
    iqe = 1; wr(0, 32'h0000_0070);
    rd(0);
    chk("R7 set wins", {31'b0, rdata[4]}, 32'h1);
    wr(0, 32'h0000_0070);
    rd(0);
    // R7: overflow with all slots full and concurrent clear
    fv = 1; finfo = 16'h7777; wr(0, 32'h1);
    rd(0);
    wr(2, 32'hFF);                // R3 drop all, pending 0
    rd(0);
    flt(16'h4444);                // R4 new rise
    rd(0);
    // R10 masked path
    wr(1, 32'h1);
    ito = 1; rd(1);
    rd(1); rd(1);
    wr(1, 32'h0);
    rd(1); rd(1); rd(1);
    // random mix
    for (int k = 0; k < 1500; k++) begin
      fv    = ($urandom % 3) == 0;
      finfo = 16'($urandom);
      ito   = ($urandom % 16) == 0;
      ice   = ($urandom % 16) == 0;
      iqe   = ($urandom % 16) == 0;
      addr  = 5'($urandom % 18);
      we    = ($urandom % 5) == 0;
      wdata = $urandom;
      @(negedge clk);
      model_step();
      compare();
    end
    fv = 0; we = 0; ito = 0; ice = 0; iqe = 0;
    rd(0);
    finish_run();
  end
endmodule